// File: doc/BRIEF.md
# Interlaced Half-Line Field Timing Generator

This block tracks vertical position in a video frame made of two fields. It counts in half-lines. A one-cycle strobe from the horizontal timing logic advances it. The length of each field is computed from a small set of vertical timing values:

- an equalisation count, weighted by three;
- an active line count, weighted by two;
- pre-blanking and post-blanking counts, with a separate pair for each field.

When a field has an odd number of half-lines, the picture interlaces without any extra control.

From the running index the block produces:

- single-cycle pulses for the start of each field and for the first and last half-line of each active window;
- a flag that tells which field is in progress;
- a vertical beam position in full lines;
- an interlace flag.

A sample strobe drives a small counter that restarts at each full line. From that counter the block reads out a clamped horizontal beam position. Timing values are taken in only at the frame wrap, so all boundaries inside one frame come from the same settings.

Top module: `halfline_field_timer`

## Requirements
- R1: After reset:
  - the index is 0 and all pulses are low;
  - the held timing is equalisation 6, active 0, first-field blanking 502 before and 5 after, second-field blanking 503 before and 4 after, line width 429;
  - as a result the frame is 1050 half-lines long and the interlace flag is 1.
- R2: Each strobe adds one to the half-line index, and the index holds between strobes. The length of a field is 3·EQ + PRE + 2·ACT + POST, using that field's own blanking pair. A strobe that would bring the index to the sum of both field lengths sets it to 0 instead.
- R3: `odd_start` is high for one cycle, the cycle after a strobe that moves the index to 0. `even_start` is high for one cycle, the cycle after a strobe that moves the index to the first-field length.
- R4: The first-field active window begins at 3·EQ + PRE_first. The second-field window begins at that same form plus the first-field length. Each window lasts 2·ACT half-lines. `act_begin` pulses when a strobe reaches a window's first index, and `act_end` pulses when a strobe reaches its last index. When ACT is 0, neither pulses.
- R5: `field_even` is 1 while the index is at or above the first-field length, and 0 below it.
- R6: `beam_v` equals 1 + floor(index / 2).
- R7: `interlaced` is 1 exactly when the first-field length is odd.
- R8: Timing inputs are loaded only by the strobe that wraps the index to 0. A change at any other time has no effect on outputs until that wrap.
- R9: A strobe that makes the index even clears the sample count. Otherwise each sample strobe adds one, stopping at 2·HLW. `beam_h` = min(1 + count, 2·HLW), and never less than 1.
- R10: All four event pulses last one cycle and occur only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | Half-line strobe |
| smp_tick | input | 1 | Pixel sample strobe |
| cfg_eq | input | 4 | Equalisation count |
| cfg_act | input | 10 | Active full lines per field |
| cfg_odd_pre | input | 10 | First-field pre-blanking half-lines |
| cfg_odd_post | input | 10 | First-field post-blanking half-lines |
| cfg_even_pre | input | 10 | Second-field pre-blanking half-lines |
| cfg_even_post | input | 10 | Second-field post-blanking half-lines |
| cfg_hlw | input | 10 | Half-line width in samples |
| hl_idx | output | 11 | Current half-line index |
| odd_start | output | 1 | First-field start pulse |
| even_start | output | 1 | Second-field start pulse |
| act_begin | output | 1 | Active window first half-line pulse |
| act_end | output | 1 | Active window last half-line pulse |
| field_even | output | 1 | Second field in progress |
| interlaced | output | 1 | First field has odd half-line count |
| beam_v | output | 11 | Vertical beam position |
| beam_h | output | 11 | Horizontal beam position |

## Verification
The assertions assume that a full frame, with both fields added together, fits within the 11-bit index range. Under that assumption a strobe either advances the index by one or wraps it to zero, and never overflows it. The stimulus keeps this true: the defaults give 1050 half-lines, and every later setting gives a frame of a few dozen half-lines. The strobe pacing varies from back-to-back to one in four, and the sample strobes are random. The configuration changes happen in the middle of a frame, so the load at the wrap is exercised.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    parameter int EQ_W  = 4;
    parameter int ACT_W = 10;
    parameter int BLK_W = 10;
    parameter int CNT_W = 11;
    parameter int HLW_W = 10;
    localparam int LEN_W  = CNT_W + 2;
    localparam int HPOS_W = HLW_W + 1;

    typedef struct packed {
        logic [EQ_W-1:0]  eq;
        logic [ACT_W-1:0] act;
        logic [BLK_W-1:0] odd_pre;
        logic [BLK_W-1:0] odd_post;
        logic [BLK_W-1:0] even_pre;
        logic [BLK_W-1:0] even_post;
        logic [HLW_W-1:0] hlw;
    } vt_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0]  idx;
        vt_cfg_t           cfg;
        logic              odd_s;
        logic              even_s;
        logic              a_beg;
        logic              a_end;
        logic [HPOS_W-1:0] smp;
    } vt_state_t;

    function automatic vt_cfg_t vt_default();
        vt_cfg_t c;
        c.eq        = EQ_W'(6);
        c.act       = '0;
        c.odd_pre   = BLK_W'(502);
        c.odd_post  = BLK_W'(5);
        c.even_pre  = BLK_W'(503);
        c.even_post = BLK_W'(4);
        c.hlw       = HLW_W'(429);
        return c;
    endfunction
endpackage

// File: rtl/vtg_field_calc.sv
module vtg_field_calc #(
    parameter int EQ_W  = 4,
    parameter int ACT_W = 10,
    parameter int BLK_W = 10,
    parameter int LEN_W = 13
) (
    input  logic [EQ_W-1:0]  eq,
    input  logic [ACT_W-1:0] act,
    input  logic [BLK_W-1:0] pre,
    input  logic [BLK_W-1:0] post,
    output logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] first,
    output logic [LEN_W-1:0] last,
    output logic             has_act
);
    logic [LEN_W-1:0] e_w, a_w, p_w, q_w, span;

    assign e_w     = LEN_W'(eq);
    assign a_w     = LEN_W'(act);
    assign p_w     = LEN_W'(pre);
    assign q_w     = LEN_W'(post);
    assign span    = a_w << 1;
    assign first   = e_w + (e_w << 1) + p_w;
    assign len     = first + span + q_w;
    assign last    = first + span - LEN_W'(1);
    assign has_act = |act;
endmodule

// File: rtl/vtg_hpos.sv
module vtg_hpos #(
    parameter int HLW_W  = 10,
    parameter int HPOS_W = 11
) (
    input  logic [HPOS_W-1:0] count,
    input  logic [HLW_W-1:0]  hlw,
    output logic [HPOS_W-1:0] pos,
    output logic              at_limit
);
    logic [HPOS_W-1:0] limit, inc, clipped;

    assign limit    = HPOS_W'(hlw) << 1;
    assign inc      = count + HPOS_W'(1);
    assign clipped  = (inc > limit) ? limit : inc;
    assign pos      = (clipped == '0) ? HPOS_W'(1) : clipped;
    assign at_limit = (count >= limit);
endmodule

// File: rtl/halfline_field_timer.sv
module halfline_field_timer
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hl_tick,
    input  logic              smp_tick,
    input  logic [EQ_W-1:0]   cfg_eq,
    input  logic [ACT_W-1:0]  cfg_act,
    input  logic [BLK_W-1:0]  cfg_odd_pre,
    input  logic [BLK_W-1:0]  cfg_odd_post,
    input  logic [BLK_W-1:0]  cfg_even_pre,
    input  logic [BLK_W-1:0]  cfg_even_post,
    input  logic [HLW_W-1:0]  cfg_hlw,
    output logic [CNT_W-1:0]  hl_idx,
    output logic              odd_start,
    output logic              even_start,
    output logic              act_begin,
    output logic              act_end,
    output logic              field_even,
    output logic              interlaced,
    output logic [CNT_W-1:0]  beam_v,
    output logic [HPOS_W-1:0] beam_h
);
    localparam int NSET = 2;  // set 0: held timing, set 1: timing after this edge

    vt_state_t st_q, st_d;
    vt_cfg_t   cfg_live, cfg_nxt;
    vt_cfg_t   cfg_set [NSET];

    logic [LEN_W-1:0] len_o   [NSET];
    logic [LEN_W-1:0] len_e   [NSET];
    logic [LEN_W-1:0] first_o [NSET];
    logic [LEN_W-1:0] first_e [NSET];
    logic [LEN_W-1:0] last_o  [NSET];
    logic [LEN_W-1:0] last_e  [NSET];
    logic             act_nz  [NSET];
    logic             act_nz_e[NSET];

    logic [LEN_W-1:0] idx_ext, idx_inc, frame_q, nxt_ext;
    logic [LEN_W-1:0] win_o_beg, win_e_beg, win_o_end, win_e_end;
    logic             wrap, at_limit;

    assign cfg_live = '{eq: cfg_eq, act: cfg_act,
                        odd_pre: cfg_odd_pre, odd_post: cfg_odd_post,
                        even_pre: cfg_even_pre, even_post: cfg_even_post,
                        hlw: cfg_hlw};

    assign cfg_set[0] = st_q.cfg;
    assign cfg_set[1] = cfg_nxt;

    generate
        for (genvar s = 0; s < NSET; s++) begin : g_set
            vtg_field_calc #(
                .EQ_W(EQ_W), .ACT_W(ACT_W), .BLK_W(BLK_W), .LEN_W(LEN_W)
            ) u_odd (
                .eq(cfg_set[s].eq), .act(cfg_set[s].act),
                .pre(cfg_set[s].odd_pre), .post(cfg_set[s].odd_post),
                .len(len_o[s]), .first(first_o[s]), .last(last_o[s]),
                .has_act(act_nz[s])
            );
            vtg_field_calc #(
                .EQ_W(EQ_W), .ACT_W(ACT_W), .BLK_W(BLK_W), .LEN_W(LEN_W)
            ) u_even (
                .eq(cfg_set[s].eq), .act(cfg_set[s].act),
                .pre(cfg_set[s].even_pre), .post(cfg_set[s].even_post),
                .len(len_e[s]), .first(first_e[s]), .last(last_e[s]),
                .has_act(act_nz_e[s])
            );
        end
    endgenerate

    vtg_hpos #(.HLW_W(HLW_W), .HPOS_W(HPOS_W)) u_hpos (
        .count(st_q.smp), .hlw(st_q.cfg.hlw), .pos(beam_h), .at_limit(at_limit)
    );

    // Frame advance: wrap decision uses the timing held for the current frame.
    always_comb begin
        idx_ext = LEN_W'(st_q.idx);
        idx_inc = idx_ext + LEN_W'(1);
        frame_q = len_o[0] + len_e[0];
        wrap    = hl_tick && (idx_inc >= frame_q);
        cfg_nxt = wrap ? cfg_live : st_q.cfg;
        if (!hl_tick)  nxt_ext = idx_ext;
        else if (wrap) nxt_ext = '0;
        else           nxt_ext = idx_inc;
    end

    // Event targets come from the timing valid after this edge.
    assign win_o_beg = first_o[1];
    assign win_o_end = last_o[1];
    assign win_e_beg = len_o[1] + first_e[1];
    assign win_e_end = len_o[1] + last_e[1];

    always_comb begin
        st_d        = st_q;
        st_d.idx    = nxt_ext[CNT_W-1:0];
        st_d.cfg    = cfg_nxt;
        st_d.odd_s  = hl_tick && (nxt_ext == '0);
        st_d.even_s = hl_tick && (nxt_ext == len_o[1]);
        st_d.a_beg  = hl_tick && act_nz[1] &&
                      ((nxt_ext == win_o_beg) || (nxt_ext == win_e_beg));
        st_d.a_end  = hl_tick && act_nz[1] &&
                      ((nxt_ext == win_o_end) || (nxt_ext == win_e_end));
        if (hl_tick && !nxt_ext[0])
            st_d.smp = '0;
        else if (smp_tick && !at_limit)
            st_d.smp = st_q.smp + HPOS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx    <= '0;
            st_q.cfg    <= vt_default();
            st_q.odd_s  <= 1'b0;
            st_q.even_s <= 1'b0;
            st_q.a_beg  <= 1'b0;
            st_q.a_end  <= 1'b0;
            st_q.smp    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hl_idx     = st_q.idx;
    assign odd_start  = st_q.odd_s;
    assign even_start = st_q.even_s;
    assign act_begin  = st_q.a_beg;
    assign act_end    = st_q.a_end;
    assign field_even = (idx_ext >= len_o[0]);
    assign interlaced = len_o[0][0];
    assign beam_v     = CNT_W'(1) + (st_q.idx >> 1);
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hl_tick,
    input logic [CNT_W-1:0]  hl_idx,
    input logic              odd_start,
    input logic              even_start,
    input logic              act_begin,
    input logic              act_end,
    input logic [HPOS_W-1:0] beam_h
);
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hl_tick |=> $stable(hl_idx)); // R2

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        hl_tick |=> (hl_idx == $past(hl_idx) + CNT_W'(1)) || (hl_idx == '0)); // R2

    AST_ODD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        odd_start |-> (hl_idx == '0)); // R3

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_start || even_start || act_begin || act_end) |-> $past(hl_tick)); // R10

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hl_tick |=> !(odd_start || even_start || act_begin || act_end)); // R10

    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_tick && hl_idx[0]) |=> (beam_h == HPOS_W'(1))); // R9
endmodule

bind halfline_field_timer vtg_checker u_vtg_checker (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .hl_idx(hl_idx),
    .odd_start(odd_start), .even_start(even_start),
    .act_begin(act_begin), .act_end(act_end), .beam_h(beam_h)
);

// File: tb/halfline_field_timer_test.sv
module halfline_field_timer_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hl_tick = 1'b0, smp_tick = 1'b0;
    logic [3:0]  cfg_eq;
    logic [9:0]  cfg_act, cfg_odd_pre, cfg_odd_post, cfg_even_pre, cfg_even_post, cfg_hlw;
    logic [10:0] hl_idx, beam_v, beam_h;
    logic        odd_start, even_start, act_begin, act_end, field_even, interlaced;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // reference model state
    int m_cnt, m_eq, m_act, m_op, m_opo, m_ep, m_epo, m_hlw, m_smp;
    bit e_os, e_es, e_ab, e_ae;

    always #(CLK_P/2) clk = ~clk;

    halfline_field_timer uut (
        .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .smp_tick(smp_tick),
        .cfg_eq(cfg_eq), .cfg_act(cfg_act),
        .cfg_odd_pre(cfg_odd_pre), .cfg_odd_post(cfg_odd_post),
        .cfg_even_pre(cfg_even_pre), .cfg_even_post(cfg_even_post),
        .cfg_hlw(cfg_hlw), .hl_idx(hl_idx),
        .odd_start(odd_start), .even_start(even_start),
        .act_begin(act_begin), .act_end(act_end),
        .field_even(field_even), .interlaced(interlaced),
        .beam_v(beam_v), .beam_h(beam_h)
    );

    function automatic int flen(int eq, int act, int pre, int post);
        return 3*eq + pre + 2*act + post;
    endfunction

    task automatic set_cfg(int eq, int act, int op, int opo, int ep, int epo, int hlw);
        cfg_eq = 4'(eq); cfg_act = 10'(act);
        cfg_odd_pre = 10'(op); cfg_odd_post = 10'(opo);
        cfg_even_pre = 10'(ep); cfg_even_post = 10'(epo);
        cfg_hlw = 10'(hlw);
    endtask

    task automatic model_reset();
        m_cnt = 0; m_eq = 6; m_act = 0; m_op = 502; m_opo = 5;
        m_ep = 503; m_epo = 4; m_hlw = 429; m_smp = 0;
        e_os = 0; e_es = 0; e_ab = 0; e_ae = 0;
    endtask

    task automatic model_step();
        int fr, oldh, nxt, ol, of_b, of_e, ef_b, ef_e;
        bit wrap;
        fr   = flen(m_eq, m_act, m_op, m_opo) + flen(m_eq, m_act, m_ep, m_epo);
        oldh = m_hlw;
        wrap = hl_tick && (m_cnt + 1 >= fr);
        if (wrap) begin // R8: load only at wrap
            m_eq = cfg_eq; m_act = cfg_act; m_op = cfg_odd_pre; m_opo = cfg_odd_post;
            m_ep = cfg_even_pre; m_epo = cfg_even_post; m_hlw = cfg_hlw;
        end
        nxt  = !hl_tick ? m_cnt : (wrap ? 0 : m_cnt + 1);
        ol   = flen(m_eq, m_act, m_op, m_opo);
        of_b = 3*m_eq + m_op;      of_e = of_b + 2*m_act - 1;
        ef_b = ol + 3*m_eq + m_ep; ef_e = ef_b + 2*m_act - 1;
        e_os = hl_tick && nxt == 0;
        e_es = hl_tick && nxt == ol;
        e_ab = hl_tick && m_act != 0 && (nxt == of_b || nxt == ef_b);
        e_ae = hl_tick && m_act != 0 && (nxt == of_e || nxt == ef_e);
        if (hl_tick && (nxt % 2) == 0) m_smp = 0;
        else if (smp_tick && m_smp < 2*oldh) m_smp++;
        m_cnt = nxt;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic compare_all();
        int ol, hx;
        ol = flen(m_eq, m_act, m_op, m_opo);
        hx = m_smp + 1;
        if (hx > 2*m_hlw) hx = 2*m_hlw;
        if (hx < 1) hx = 1;
        chk("R2 hl_idx", int'(hl_idx), m_cnt);
        chk("R3 odd_start", int'(odd_start), int'(e_os));
        chk("R3 even_start", int'(even_start), int'(e_es));
        chk("R4 act_begin", int'(act_begin), int'(e_ab));
        chk("R4 act_end", int'(act_end), int'(e_ae));
        chk("R5 field_even", int'(field_even), int'(m_cnt >= ol));
        chk("R6 beam_v", int'(beam_v), 1 + m_cnt/2);
        chk("R7 interlaced", int'(interlaced), ol % 2);
        chk("R9 beam_h", int'(beam_h), hx);
    endtask

    task automatic run_phase(int n, int per);
        for (int i = 0; i < n; i++) begin
            hl_tick  = ((i % per) == 0);
            smp_tick = 1'($urandom_range(0, 1));
            model_step(); // R10 pulses tracked per strobe
            @(negedge clk);
            cyc++;
            compare_all();
        end
    endtask

    initial begin
        set_cfg(6, 0, 502, 5, 503, 4, 429);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state (frame 1050, interlace 1, beam_h 1)
        compare_all();
        chk("R1 interlaced default", int'(interlaced), 1);
        rst_n = 1'b1;
        // defaults across a full frame and into the next
        run_phase(2400, 2);
        // R8: mid-frame change must wait for the wrap
        set_cfg(1, 3, 2, 1, 3, 1, 3);
        run_phase(2000, 2);
        // zero pre-blanking: window starts at index 0; back-to-back strobes
        set_cfg(0, 2, 0, 3, 1, 2, 2);
        run_phase(300, 1);
        // no active lines: no window pulses (R4); sparse strobes
        set_cfg(2, 0, 1, 0, 0, 1, 5);
        run_phase(800, 4);
        // zero line width: beam_h floor of 1 (R9)
        set_cfg(1, 1, 1, 1, 2, 1, 0);
        run_phase(300, 3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule